// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the data side of a small multi-cycle processor in which every value moves over one shared 32-bit bus. In any cycle one of four sources places a word on the bus: the immediate generator, the register RAM, the ALU or the memory read port. Four latches can capture the bus at the next clock edge: operand A, operand B, the memory address latch and the instruction latch. The register RAM can also be written from the bus. It holds the 32 integer registers and, as one extra entry, the program counter. Because of this, incrementing the PC and forming branch targets are ordinary bus transfers through the ALU.

An external sequencer supplies one flat control word each cycle. The block gives back the opcode field of the instruction latch and a condition bit, which the sequencer uses to branch. The memory port presents the address latch, the bus value as write data and a write enable. It accepts read data and a busy flag. While memory is busy, a transfer sourced from memory does not commit.

Top module: `sbus_top`

## Requirements
- R1: `ctrlWord` bits, from bit 0 up, are: srcImm (0), srcReg (1), srcAlu (2), srcMem (3), latA (4), latB (5), latAddr (6), latInst (7), rfWrite (8) and memWrite (9). rfPick is bits 11:10, immKind is bits 13:12 and aluFn is bits 17:14. When no source bit is set, the bus carries zero.
- R2: After reset, every register entry, the PC, operand A, operand B, the address latch and the instruction latch are zero.
- R3: The bus carries the word from whichever source bit is set: immediate, register read data, ALU result or `memRData`. Setting more than one source bit in a cycle is a protocol error and is flagged.
- R4: Each of latA, latB, latAddr and latInst loads that latch from the bus at the clock edge. Without its bit, the latch keeps its value even when the bus is driven.
- R5: rfPick selects the register entry: 0 is the PC, 1 is instruction bits 11:7, 2 is bits 19:15 and 3 is bits 24:20. srcReg reads the selected entry onto the bus. rfWrite writes the bus into it at the edge.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: The PC entry can be read, written and incremented through the bus. `memAddr` always shows the address latch.
- R8: immKind selects the immediate, which is sign-extended from instruction bit 31. Code 0 gives bits 31:20. Code 1 gives {31:25, 11:7}. Code 2 gives {31, 7, 30:25, 11:8, 0}. Code 3 gives {31, 19:12, 20, 30:21, 0}.
- R9: The ALU computes from A and B according to aluFn. The codes are: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right (shift amount B[4:0]), 8 equal, 9 not equal, 10 signed less, 11 signed greater-or-equal, 12 unsigned less, 13 unsigned greater-or-equal, 14 A+4 and 15 A-4. A compare returns 1 or 0.
- R10: `cond` is the compare outcome for aluFn codes 8 to 13 and 0 for all other codes.
- R11: While `memBusy` is high and memory is the bus source, no latch and no register entry is updated.
- R12: `memWe` follows memWrite. `memWData` is the bus value. `opcode` is bits 6:0 of the instruction latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 18 | Flat control word for this cycle |
| memRData | input | 32 | Memory read data |
| memBusy | input | 1 | Memory has not completed |
| memAddr | output | 32 | Address latch contents |
| memWData | output | 32 | Write data (bus value) |
| memWe | output | 1 | Memory write enable |
| opcode | output | 7 | Opcode field of instruction latch |
| cond | output | 1 | Compare outcome of selected ALU function |

## Verification
The bench builds the block with its default widths: a 32-bit word and 32 integer registers, so the PC sits at entry 32. With these values, shifts by 31 and operands whose bit 31 is set become reachable. This makes the difference between signed and unsigned compares, and between arithmetic and logical shifts, visible. The 32-bit word also lets each immediate format be checked with a sign bit that has to spread across the upper bits.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {PICK_PC, PICK_RD, PICK_RS1, PICK_RS2} rfPick_e;
  typedef enum logic [1:0] {IMM_I, IMM_S, IMM_B, IMM_J} immKind_e;
  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLL, FN_SRL, FN_SRA,
    FN_EQ, FN_NE, FN_LT, FN_GE, FN_LTU, FN_GEU, FN_INC4, FN_DEC4
  } aluFn_e;

  typedef struct packed {
    aluFn_e   aluFn;
    immKind_e immKind;
    rfPick_e  rfPick;
    logic     memWrite;
    logic     rfWrite;
    logic     latInst;
    logic     latAddr;
    logic     latB;
    logic     latA;
    logic     srcMem;
    logic     srcAlu;
    logic     srcReg;
    logic     srcImm;
  } ctrlWord_t;

  localparam int CTRL_W = $bits(ctrlWord_t);
  localparam int IDX_W  = 5;
  localparam int OPC_W  = 7;

  typedef struct packed {
    logic             drvImm;
    logic             drvReg;
    logic             drvAlu;
    logic             drvMem;
    logic             ldA;
    logic             ldB;
    logic             ldMa;
    logic             ldIr;
    logic             rfWe;
    logic             rfPc;
    logic [IDX_W-1:0] rfIdx;
    logic             memWe;
    immKind_e         immKind;
    aluFn_e           aluFn;
  } strobe_t;
endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlWord_t        cw,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [IDX_W-1:0] rs1Idx,
  input  logic [IDX_W-1:0] rs2Idx,
  input  logic             memBusy,
  output strobe_t          stb
);
  logic stall;

  always_comb begin
    stb        = '0;
    stb.drvImm = cw.srcImm;
    stb.drvReg = cw.srcReg & ~cw.srcImm;
    stb.drvAlu = cw.srcAlu & ~cw.srcImm & ~cw.srcReg;
    stb.drvMem = cw.srcMem & ~cw.srcImm & ~cw.srcReg & ~cw.srcAlu;
    stall      = stb.drvMem & memBusy;
    stb.ldA    = cw.latA    & ~stall;
    stb.ldB    = cw.latB    & ~stall;
    stb.ldMa   = cw.latAddr & ~stall;
    stb.ldIr   = cw.latInst & ~stall;
    stb.rfWe   = cw.rfWrite & ~stall;
    stb.rfPc   = (cw.rfPick == PICK_PC);
    unique case (cw.rfPick)
      PICK_RD:  stb.rfIdx = rdIdx;
      PICK_RS1: stb.rfIdx = rs1Idx;
      PICK_RS2: stb.rfIdx = rs2Idx;
      default:  stb.rfIdx = '0;
    endcase
    stb.memWe   = cw.memWrite;
    stb.immKind = cw.immKind;
    stb.aluFn   = cw.aluFn;
  end

  // R3
  bus_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cw.srcImm, cw.srcReg, cw.srcAlu, cw.srcMem}));
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic             isPc,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  wData,
  output logic [XLEN-1:0]  rData
);
  localparam int NENT = NREGS + 1;
  localparam int AW   = $clog2(NENT);

  logic [AW-1:0]   addr;
  logic [XLEN-1:0] ent [NENT];

  assign addr = isPc ? AW'(NREGS) : AW'(idx);

  for (genvar g = 0; g < NENT; g++) begin : gEnt
    if (g == 0) begin : gZero
      assign ent[g] = '0;
    end else begin : gReg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN)                      q <= '0;
        else if (we && addr == AW'(g))  q <= wData;
      end
      assign ent[g] = q;
    end
  end

  assign rData = ent[addr];

  // R6
  x0_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isPc && idx == '0) |-> (rData == '0));
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  aluFn_e          fn,
  output logic [XLEN-1:0] res,
  output logic            cond
);
  localparam int SH_W = $clog2(XLEN);

  logic [SH_W-1:0] sh;
  logic            isCmp;

  assign sh = b[SH_W-1:0];

  always_comb begin
    cond  = 1'b0;
    isCmp = 1'b1;
    unique case (fn)
      FN_EQ:   cond = (a == b);
      FN_NE:   cond = (a != b);
      FN_LT:   cond = ($signed(a) <  $signed(b));
      FN_GE:   cond = ($signed(a) >= $signed(b));
      FN_LTU:  cond = (a <  b);
      FN_GEU:  cond = (a >= b);
      default: isCmp = 1'b0;
    endcase
    unique case (fn)
      FN_ADD:  res = a + b;
      FN_SUB:  res = a - b;
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_XOR:  res = a ^ b;
      FN_SLL:  res = a << sh;
      FN_SRL:  res = a >> sh;
      FN_SRA:  res = XLEN'($signed(a) >>> sh);
      FN_INC4: res = a + XLEN'(4);
      FN_DEC4: res = a - XLEN'(4);
      default: res = isCmp ? XLEN'(cond) : '0;
    endcase
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [XLEN-1:0]  memRData,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWData,
  output logic             memWe,
  output logic [OPC_W-1:0] opcode,
  output logic             cond,
  output logic [IDX_W-1:0] rdIdx,
  output logic [IDX_W-1:0] rs1Idx,
  output logic [IDX_W-1:0] rs2Idx
);
  logic [XLEN-1:0] aReg, bReg, maReg, irReg;
  logic [XLEN-1:0] bus, immVal, rfData, aluRes;

  always_comb begin
    unique case (stb.immKind)
      IMM_I:   immVal = {{(XLEN-12){irReg[31]}}, irReg[31:20]};
      IMM_S:   immVal = {{(XLEN-12){irReg[31]}}, irReg[31:25], irReg[11:7]};
      IMM_B:   immVal = {{(XLEN-13){irReg[31]}}, irReg[31], irReg[7],
                         irReg[30:25], irReg[11:8], 1'b0};
      default: immVal = {{(XLEN-21){irReg[31]}}, irReg[31], irReg[19:12],
                         irReg[20], irReg[30:21], 1'b0};
    endcase
  end

  sbus_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk), .rstN(rstN), .we(stb.rfWe), .isPc(stb.rfPc),
    .idx(stb.rfIdx), .wData(bus), .rData(rfData)
  );

  sbus_alu #(.XLEN(XLEN)) u_alu (
    .a(aReg), .b(bReg), .fn(stb.aluFn), .res(aluRes), .cond(cond)
  );

  always_comb begin
    if      (stb.drvImm) bus = immVal;
    else if (stb.drvReg) bus = rfData;
    else if (stb.drvAlu) bus = aluRes;
    else if (stb.drvMem) bus = memRData;
    else                 bus = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg  <= '0;
      bReg  <= '0;
      maReg <= '0;
      irReg <= '0;
    end else begin
      if (stb.ldA)  aReg  <= bus;
      if (stb.ldB)  bReg  <= bus;
      if (stb.ldMa) maReg <= bus;
      if (stb.ldIr) irReg <= bus;
    end
  end

  assign memAddr  = maReg;
  assign memWData = bus;
  assign memWe    = stb.memWe;
  assign opcode   = irReg[OPC_W-1:0];
  assign rdIdx    = irReg[11:7];
  assign rs1Idx   = irReg[19:15];
  assign rs2Idx   = irReg[24:20];

  // R4
  a_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldA |=> (aReg == $past(bus)));
  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldA |=> $stable(aReg));
  // R12
  opcode_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldIr |=> (opcode == $past(bus[OPC_W-1:0])));
endmodule

// File: rtl/sbus_top.sv
module sbus_top
  import sbus_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [XLEN-1:0]   memRData,
  input  logic              memBusy,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWData,
  output logic              memWe,
  output logic [OPC_W-1:0]  opcode,
  output logic              cond
);
  ctrlWord_t        cw;
  strobe_t          stb;
  logic [IDX_W-1:0] rdIdx, rs1Idx, rs2Idx;

  assign cw = ctrlWord_t'(ctrlWord);

  sbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cw(cw), .rdIdx(rdIdx), .rs1Idx(rs1Idx),
    .rs2Idx(rs2Idx), .memBusy(memBusy), .stb(stb)
  );

  sbus_datapath #(.XLEN(XLEN), .NREGS(NREGS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData), .memWe(memWe),
    .opcode(opcode), .cond(cond), .rdIdx(rdIdx), .rs1Idx(rs1Idx),
    .rs2Idx(rs2Idx)
  );

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cw.srcMem && !cw.srcImm && !cw.srcReg && !cw.srcAlu && memBusy)
      |=> ($stable(opcode) && $stable(memAddr)));
endmodule

// File: tb/sbus_top_tb.sv
module sbus_top_tb;
  import sbus_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CTRL_W-1:0] ctrlWord = '0;
  logic [31:0]       memRData = '0;
  logic              memBusy = 1'b0;
  logic [31:0]       memAddr, memWData;
  logic              memWe, cond;
  logic [6:0]        opcode;

  int nChecks = 0;
  int nErrs   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sbus_top u_dut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .memRData(memRData),
    .memBusy(memBusy), .memAddr(memAddr), .memWData(memWData),
    .memWe(memWe), .opcode(opcode), .cond(cond)
  );

  // fn, a, b, result, cond
  localparam logic [100:0] VEC [16] = '{
    {4'd0,  32'd7,        32'd5,        32'd12,       1'b0},
    {4'd1,  32'd5,        32'd7,        32'hFFFFFFFE, 1'b0},
    {4'd2,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0},
    {4'd3,  32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0},
    {4'd4,  32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0},
    {4'd5,  32'd1,        32'd31,       32'h80000000, 1'b0},
    {4'd6,  32'h80000000, 32'd4,        32'h08000000, 1'b0},
    {4'd7,  32'h80000000, 32'd4,        32'hF8000000, 1'b0},
    {4'd8,  32'd5,        32'd5,        32'd1,        1'b1},
    {4'd9,  32'd5,        32'd5,        32'd0,        1'b0},
    {4'd10, 32'hFFFFFFFF, 32'd1,        32'd1,        1'b1},
    {4'd11, 32'hFFFFFFFF, 32'd1,        32'd0,        1'b0},
    {4'd12, 32'hFFFFFFFF, 32'd1,        32'd0,        1'b0},
    {4'd13, 32'hFFFFFFFF, 32'd1,        32'd1,        1'b1},
    {4'd14, 32'd100,      32'd9,        32'd104,      1'b0},
    {4'd15, 32'd100,      32'd9,        32'd96,       1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(input ctrlWord_t c, input logic [31:0] rd, input logic bz);
    @(negedge clk);
    ctrlWord = c;
    memRData = rd;
    memBusy  = bz;
    #1;
  endtask

  function automatic ctrlWord_t memTo(input bit la, input bit lb, input bit li);
    ctrlWord_t c = '0;
    c.srcMem = 1'b1; c.latA = la; c.latB = lb; c.latInst = li;
    return c;
  endfunction

  function automatic ctrlWord_t rdReg(input rfPick_e p);
    ctrlWord_t c = '0;
    c.srcReg = 1'b1; c.rfPick = p;
    return c;
  endfunction

  function automatic ctrlWord_t alu(input aluFn_e f);
    ctrlWord_t c = '0;
    c.srcAlu = 1'b1; c.aluFn = f;
    return c;
  endfunction

  function automatic logic [31:0] encI(input logic [31:0] v);
    return {v[11:0], 5'd1, 3'd0, 5'd2, 7'h13};
  endfunction
  function automatic logic [31:0] encS(input logic [31:0] v);
    return {v[11:5], 5'd3, 5'd1, 3'd2, v[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] encB(input logic [31:0] v);
    return {v[12], v[10:5], 5'd3, 5'd1, 3'd0, v[4:1], v[11], 7'h63};
  endfunction
  function automatic logic [31:0] encJ(input logic [31:0] v);
    return {v[20], v[10:1], v[11], v[19:12], 5'd1, 7'h6F};
  endfunction

  task automatic immTest(input immKind_e k, input logic [31:0] instr, input logic [31:0] exp);
    ctrlWord_t c = '0;
    go(memTo(0, 0, 1), instr, 1'b0);
    c.srcImm = 1'b1; c.immKind = k;
    go(c, 32'h0, 1'b0);
    chk("R8 immediate", memWData, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nErrs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    ctrlWord_t c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state, R1 idle bus
    go('0, 32'hAAAA5555, 1'b0);
    chk("R1 idle bus zero", memWData, 32'h0);
    chk("R2 address latch reset", memAddr, 32'h0);
    chk("R2 opcode reset", {25'h0, opcode}, 32'h0);
    go(rdReg(PICK_PC), 32'h0, 1'b0);
    chk("R2 pc reset", memWData, 32'h0);
    go(rdReg(PICK_RS2), 32'h0, 1'b0);
    chk("R2 register reset", memWData, 32'h0);

    // R9 R10 R3 R4 ALU table
    for (int i = 0; i < 16; i++) begin
      go(memTo(1, 0, 0), VEC[i][96:65], 1'b0);
      go(memTo(0, 1, 0), VEC[i][64:33], 1'b0);
      go(alu(aluFn_e'(VEC[i][100:97])), 32'h0, 1'b0);
      chk("R9 alu result", memWData, VEC[i][32:1]);
      chk("R10 cond", {31'h0, cond}, {31'h0, VEC[i][0]});
    end

    // R3 memory source reaches bus; R12 opcode and write port
    go(memTo(0, 0, 1), {7'd0, 5'd6, 5'd5, 3'd0, 5'd5, 7'h33}, 1'b0);
    chk("R3 memory source on bus", memWData, {7'd0, 5'd6, 5'd5, 3'd0, 5'd5, 7'h33});
    go('0, 32'h0, 1'b0);
    chk("R12 opcode", {25'h0, opcode}, 32'h33);

    // R5 write rd (x5) then read via rs1, rs2 (x6) untouched
    c = memTo(0, 0, 0); c.rfWrite = 1'b1; c.rfPick = PICK_RD;
    go(c, 32'h12345678, 1'b0);
    go(rdReg(PICK_RS1), 32'h0, 1'b0);
    chk("R5 register write/read", memWData, 32'h12345678);
    go(rdReg(PICK_RS2), 32'h0, 1'b0);
    chk("R5 other register untouched", memWData, 32'h0);

    // R6 x0 discards writes
    go(memTo(0, 0, 1), {7'd0, 5'd0, 5'd0, 3'd0, 5'd0, 7'h33}, 1'b0);
    c = memTo(0, 0, 0); c.rfWrite = 1'b1; c.rfPick = PICK_RD;
    go(c, 32'hDEADBEEF, 1'b0);
    go(rdReg(PICK_RS1), 32'h0, 1'b0);
    chk("R6 x0 reads zero", memWData, 32'h0);

    // R7 PC write, address latch, increment
    c = memTo(0, 0, 0); c.rfWrite = 1'b1; c.rfPick = PICK_PC;
    go(c, 32'h00000100, 1'b0);
    c = rdReg(PICK_PC); c.latA = 1'b1; c.latAddr = 1'b1;
    go(c, 32'h0, 1'b0);
    c = alu(FN_INC4); c.rfWrite = 1'b1; c.rfPick = PICK_PC;
    go(c, 32'h0, 1'b0);
    chk("R7 memAddr from pc", memAddr, 32'h00000100);
    chk("R7 pc plus four on bus", memWData, 32'h00000104);
    go(rdReg(PICK_PC), 32'h0, 1'b0);
    chk("R7 pc updated", memWData, 32'h00000104);

    // R12 write port
    c = rdReg(PICK_PC); c.memWrite = 1'b1;
    go(c, 32'h0, 1'b0);
    chk("R12 memWe high", {31'h0, memWe}, 32'h1);
    chk("R12 write data is bus", memWData, 32'h00000104);
    go('0, 32'h0, 1'b0);
    chk("R12 memWe low", {31'h0, memWe}, 32'h0);

    // R8 immediates
    immTest(IMM_I, encI(32'hFFFFFFFB), 32'hFFFFFFFB);
    immTest(IMM_S, encS(32'h000007F5), 32'h000007F5);
    immTest(IMM_B, encB(32'hFFFFF0A6), 32'hFFFFF0A6);
    immTest(IMM_J, encJ(32'h000FFFFE), 32'h000FFFFE);
    immTest(IMM_J, encJ(32'hFFF00000), 32'hFFF00000);

    // R11 busy stall, R4 hold without load
    go(memTo(1, 1, 0), 32'h00000011, 1'b0);
    go(memTo(0, 0, 1), {25'h0, 7'h13}, 1'b0);
    c = memTo(1, 0, 1); c.latAddr = 1'b1; c.rfWrite = 1'b1; c.rfPick = PICK_PC;
    go(c, 32'h00000099, 1'b1);
    go(memTo(0, 0, 0), 32'h00000077, 1'b0);
    chk("R11 opcode held while busy", {25'h0, opcode}, 32'h13);
    chk("R11 address latch held while busy", memAddr, 32'h00000100);
    go(alu(FN_SUB), 32'h0, 1'b0);
    chk("R11 R4 operand A held", memWData, 32'h0);
    go(rdReg(PICK_PC), 32'h0, 1'b0);
    chk("R11 pc not written while busy", memWData, 32'h00000104);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule